// File: doc/BRIEF.md
# Three-State Line Coherence Decision Unit

This unit decides, for one data-cache access at a time, what the cache and the bus must do under a three-state ownership scheme: Invalid, Exclusive and Modified, with no shared state. Each cycle it may take one load or store request. The request carries the addressed line's current state, the tag-compare result, the dirty status of the replacement victim and the page attributes (write-through, caching-inhibited, coherence-required).

One clock later it returns a registered decision. The decision holds the state to write back into the line's tags, a set of action flags and the bus transaction to queue. The action flags are victim cast-out, line fill, internal retry, write-queue push, cache data read and cache data write. The bus transaction is read, read-with-intent-to-modify, write-with-flush or write-with-kill, with a single-beat or four-beat length.

A retried access is meant to be presented again by the caller on the next cycle. By then it sees the line state this unit just produced. The data arrays, the bus itself, snooping and reservation tracking for atomic operations sit outside.

Top module: `mei_coherence_ctrl`

## Requirements
- R1: Encodings are fixed. Line state uses 00 Invalid, 01 Exclusive, 10 Modified; 11 is reserved and is treated as Invalid. Bus type uses 00 read, 01 read-with-intent-to-modify, 10 write-with-flush, 11 write-with-kill. Under synchronous reset every output is 0. For a request presented at one rising edge, rsp_valid and the decision appear after that edge and hold until the next one. With req_valid low, every output is 0 in the next cycle.
- R2: A load that is not caching-inhibited and misses does three things: it sets do_fill, issues a four-beat read (bus_burst=1), and sets the next state to Exclusive. do_castout equals victim_dirty. The write-through bit has no effect on loads.
- R3: A load that is not caching-inhibited and hits Exclusive or Modified sets cache_rd, issues no bus request and keeps the state.
- R4: A caching-inhibited load miss issues a single-beat read and leaves the line Invalid, with no fill and no cast-out.
- R5: A caching-inhibited load or store that hits Exclusive sets do_retry and moves the line to Invalid, with no bus request and no cache data access.
- R6: A caching-inhibited load or store that hits Modified does several things: it sets do_retry and do_push, issues a four-beat write-with-kill and moves the line to Invalid.
- R7: A copy-back store miss (neither attribute set) sets do_fill, issues a four-beat read-with-intent-to-modify and sets the next state to Modified. do_castout equals victim_dirty.
- R8: A copy-back store that hits Exclusive or Modified sets cache_wr, issues no bus request and moves the line to Modified.
- R9: A write-through store miss or a caching-inhibited store miss issues a single-beat write-with-flush and leaves the line Invalid.
- R10: A write-through store hitting Exclusive sets cache_wr, issues a single-beat write-with-flush and keeps the line Exclusive.
- R11: A write-through store hitting Modified sets do_retry and do_push and issues a four-beat write-with-kill. It moves the line to Exclusive, so the retried store then takes the R10 path.
- R12: A tag match on an Invalid or reserved line counts as a miss. victim_dirty has no effect on any hit or on any caching-inhibited or write-through access.
- R13: bus_global equals the coherence-required attribute when a bus request is issued and is 0 otherwise. That attribute changes no other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 store, 0 load |
| line_state | input | 2 | Current state of the addressed line |
| tag_hit | input | 1 | Tag compare matched |
| victim_dirty | input | 1 | Replacement victim is Modified |
| attr_wt | input | 1 | Write-through page |
| attr_ci | input | 1 | Caching-inhibited page |
| attr_gbl | input | 1 | Coherence-required page |
| rsp_valid | output | 1 | Decision valid |
| nxt_state | output | 2 | State to write into the line |
| do_castout | output | 1 | Write victim out with write-with-kill before the bus request |
| do_fill | output | 1 | Allocate and fill the line |
| do_retry | output | 1 | Re-present the access next cycle |
| do_push | output | 1 | Push the line to the write queue |
| cache_rd | output | 1 | Read data from the cache |
| cache_wr | output | 1 | Write data into the cache |
| bus_req | output | 1 | Queue a bus transaction |
| bus_type | output | 2 | Transaction type |
| bus_burst | output | 1 | 1 four-beat, 0 single-beat |
| bus_global | output | 1 | Transaction must be snooped |

## Verification
Directed cases walk each attribute combination (copy-back, write-through, caching-inhibited, both attributes set) against Invalid, Exclusive, Modified and reserved states, for loads and stores. This separates paths that differ only in state, such as write-through hits on Exclusive versus Modified. A tag match on an Invalid line is contrasted with a real hit, and the victim-dirty and coherence bits are toggled on the same access to show where they may and may not matter. A retry sequence feeds the produced state back as the next access, and a long random run with idle gaps covers mixed back-to-back traffic.

// File: rtl/mei_pkg.sv
package mei_pkg;
  localparam int ST_W = 2;
  localparam int BT_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_INV = 2'b00,
    ST_EXC = 2'b01,
    ST_MOD = 2'b10,
    ST_RSV = 2'b11
  } line_st_e;

  typedef enum logic [BT_W-1:0] {
    BT_READ  = 2'b00,
    BT_RWITM = 2'b01,
    BT_WWF   = 2'b10,
    BT_WWK   = 2'b11
  } bus_t_e;

  typedef enum logic [1:0] {
    MODE_CB = 2'd0,
    MODE_WT = 2'd1,
    MODE_CI = 2'd2
  } acc_mode_e;

  typedef struct packed {
    line_st_e nxt;
    logic     castout;
    logic     fill;
    logic     retry;
    logic     push;
    logic     crd;
    logic     cwr;
    logic     bvld;
    bus_t_e   btype;
    logic     burst;
    logic     glb;
  } mei_dec_t;

  localparam int DEC_W = $bits(mei_dec_t);
endpackage

// File: rtl/mei_classify.sv
module mei_classify
  import mei_pkg::*;
(
  input  logic [ST_W-1:0] line_state,
  input  logic            tag_hit,
  input  logic            attr_wt,
  input  logic            attr_ci,
  output acc_mode_e       mode,
  output logic            hit_exc,
  output logic            hit_mod,
  output logic            miss
);
  line_st_e st;

  always_comb begin
    st      = line_st_e'(line_state);
    hit_exc = tag_hit && (st == ST_EXC);
    hit_mod = tag_hit && (st == ST_MOD);
    miss    = !(hit_exc || hit_mod);
    if (attr_ci)      mode = MODE_CI;
    else if (attr_wt) mode = MODE_WT;
    else              mode = MODE_CB;
  end
endmodule

// File: rtl/mei_decode.sv
module mei_decode
  import mei_pkg::*;
(
  input  logic            req_valid,
  input  logic            req_store,
  input  logic [ST_W-1:0] line_state,
  input  acc_mode_e       mode,
  input  logic            hit_exc,
  input  logic            hit_mod,
  input  logic            miss,
  input  logic            victim_dirty,
  input  logic            attr_gbl,
  output mei_dec_t        dec
);
  always_comb begin
    dec = '0;
    if (req_valid) begin
      unique case (mode)
        MODE_CI: begin
          dec.nxt = ST_INV;
          if (miss) begin
            dec.bvld  = 1'b1;
            dec.btype = req_store ? BT_WWF : BT_READ;
          end else if (hit_exc) begin
            dec.retry = 1'b1;
          end else begin
            dec.retry = 1'b1;
            dec.push  = 1'b1;
            dec.bvld  = 1'b1;
            dec.btype = BT_WWK;
            dec.burst = 1'b1;
          end
        end
        MODE_WT: begin
          if (!req_store) begin
            if (miss) begin
              dec.castout = victim_dirty;
              dec.fill    = 1'b1;
              dec.bvld    = 1'b1;
              dec.btype   = BT_READ;
              dec.burst   = 1'b1;
              dec.nxt     = ST_EXC;
            end else begin
              dec.crd = 1'b1;
              dec.nxt = line_st_e'(line_state);
            end
          end else if (miss) begin
            dec.bvld  = 1'b1;
            dec.btype = BT_WWF;
            dec.nxt   = ST_INV;
          end else if (hit_exc) begin
            dec.cwr   = 1'b1;
            dec.bvld  = 1'b1;
            dec.btype = BT_WWF;
            dec.nxt   = ST_EXC;
          end else begin
            dec.retry = 1'b1;
            dec.push  = 1'b1;
            dec.bvld  = 1'b1;
            dec.btype = BT_WWK;
            dec.burst = 1'b1;
            dec.nxt   = ST_EXC;
          end
        end
        default: begin
          if (miss) begin
            dec.castout = victim_dirty;
            dec.fill    = 1'b1;
            dec.bvld    = 1'b1;
            dec.btype   = req_store ? BT_RWITM : BT_READ;
            dec.burst   = 1'b1;
            dec.nxt     = req_store ? ST_MOD : ST_EXC;
          end else if (req_store) begin
            dec.cwr = 1'b1;
            dec.nxt = ST_MOD;
          end else begin
            dec.crd = 1'b1;
            dec.nxt = line_st_e'(line_state);
          end
        end
      endcase
      dec.glb = dec.bvld & attr_gbl;
    end
  end
endmodule

// File: rtl/mei_out_reg.sv
module mei_out_reg
  import mei_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     vld_in,
  input  mei_dec_t dec_in,
  output logic     vld_q,
  output mei_dec_t dec_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      dec_q <= '0;
    end else begin
      vld_q <= vld_in;
      dec_q <= dec_in;
    end
  end
endmodule

// File: rtl/mei_coherence_ctrl.sv
module mei_coherence_ctrl
  import mei_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_store,
  input  logic [ST_W-1:0] line_state,
  input  logic            tag_hit,
  input  logic            victim_dirty,
  input  logic            attr_wt,
  input  logic            attr_ci,
  input  logic            attr_gbl,
  output logic            rsp_valid,
  output logic [ST_W-1:0] nxt_state,
  output logic            do_castout,
  output logic            do_fill,
  output logic            do_retry,
  output logic            do_push,
  output logic            cache_rd,
  output logic            cache_wr,
  output logic            bus_req,
  output logic [BT_W-1:0] bus_type,
  output logic            bus_burst,
  output logic            bus_global
);
  acc_mode_e mode;
  logic      hit_exc, hit_mod, miss;
  mei_dec_t  dec_d, dec_q;

  mei_classify u_cls (
    .line_state (line_state),
    .tag_hit    (tag_hit),
    .attr_wt    (attr_wt),
    .attr_ci    (attr_ci),
    .mode       (mode),
    .hit_exc    (hit_exc),
    .hit_mod    (hit_mod),
    .miss       (miss)
  );

  mei_decode u_dec (
    .req_valid    (req_valid),
    .req_store    (req_store),
    .line_state   (line_state),
    .mode         (mode),
    .hit_exc      (hit_exc),
    .hit_mod      (hit_mod),
    .miss         (miss),
    .victim_dirty (victim_dirty),
    .attr_gbl     (attr_gbl),
    .dec          (dec_d)
  );

  mei_out_reg u_reg (
    .clk    (clk),
    .rst    (rst),
    .vld_in (req_valid),
    .dec_in (dec_d),
    .vld_q  (rsp_valid),
    .dec_q  (dec_q)
  );

  assign nxt_state  = dec_q.nxt;
  assign do_castout = dec_q.castout;
  assign do_fill    = dec_q.fill;
  assign do_retry   = dec_q.retry;
  assign do_push    = dec_q.push;
  assign cache_rd   = dec_q.crd;
  assign cache_wr   = dec_q.cwr;
  assign bus_req    = dec_q.bvld;
  assign bus_type   = dec_q.btype;
  assign bus_burst  = dec_q.burst;
  assign bus_global = dec_q.glb;
endmodule

// File: rtl/mei_chk.sv
module mei_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_store,
  input logic [1:0] line_state,
  input logic       tag_hit,
  input logic       victim_dirty,
  input logic       attr_wt,
  input logic       attr_ci,
  input logic       attr_gbl,
  input logic       rsp_valid,
  input logic [1:0] nxt_state,
  input logic       do_castout,
  input logic       do_fill,
  input logic       do_retry,
  input logic       do_push,
  input logic       cache_rd,
  input logic       cache_wr,
  input logic       bus_req,
  input logic [1:0] bus_type,
  input logic       bus_burst,
  input logic       bus_global
);
  AST_RSP_TRACKS_REQ: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rsp_valid == $past(req_valid)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(do_castout || do_fill || do_retry || do_push || cache_rd || cache_wr || bus_req)); // R1
  AST_FILL_IS_BURST: assert property (@(posedge clk) disable iff (rst)
    do_fill |-> bus_req && bus_burst && (bus_type == 2'b00 || bus_type == 2'b01)); // R2
  AST_CASTOUT_NEEDS_FILL: assert property (@(posedge clk) disable iff (rst)
    do_castout |-> do_fill); // R7
  AST_PUSH_IS_WWK: assert property (@(posedge clk) disable iff (rst)
    do_push |-> do_retry && bus_req && bus_type == 2'b11 && bus_burst); // R6
  AST_RETRY_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    do_retry |-> !cache_rd && !cache_wr && !do_fill); // R5
  AST_CI_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(req_valid && attr_ci) |-> nxt_state == 2'b00 && !do_fill); // R4
  AST_GLOBAL_ONLY_ON_BUS: assert property (@(posedge clk) disable iff (rst)
    bus_global |-> bus_req); // R13
endmodule

bind mei_coherence_ctrl mei_chk u_chk (.*);

// File: tb/tb_mei_coherence_ctrl.sv
module tb_mei_coherence_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_store = 1'b0, tag_hit = 1'b0, victim_dirty = 1'b0;
  logic attr_wt = 1'b0, attr_ci = 1'b0, attr_gbl = 1'b0;
  logic [1:0] line_state = 2'b00;
  logic rsp_valid, do_castout, do_fill, do_retry, do_push, cache_rd, cache_wr;
  logic bus_req, bus_burst, bus_global;
  logic [1:0] nxt_state, bus_type;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mei_coherence_ctrl dut (.*);

  function automatic logic [14:0] model(input logic v, st, input logic [1:0] s,
                                        input logic h, vd, wt, ci, g);
    logic eh, em, co, fl, rt, pu, rd, wr, bv, bb;
    logic [1:0] ns, bt;
    eh = h && (s == 2'b01 || s == 2'b10);
    em = h && (s == 2'b10);
    {co, fl, rt, pu, rd, wr, bv, bb} = '0;
    ns = 2'b00; bt = 2'b00;
    if (!v) return '0;
    if (ci) begin
      if (!eh) begin bv = 1; bt = st ? 2'b10 : 2'b00; end
      else if (!em) rt = 1;
      else begin rt = 1; pu = 1; bv = 1; bt = 2'b11; bb = 1; end
    end else if (!st) begin
      if (!eh) begin co = vd; fl = 1; bv = 1; bb = 1; ns = 2'b01; end
      else begin rd = 1; ns = s; end
    end else if (!wt) begin
      if (!eh) begin co = vd; fl = 1; bv = 1; bt = 2'b01; bb = 1; ns = 2'b10; end
      else begin wr = 1; ns = 2'b10; end
    end else begin
      if (!eh) begin bv = 1; bt = 2'b10; end
      else if (!em) begin wr = 1; bv = 1; bt = 2'b10; ns = 2'b01; end
      else begin rt = 1; pu = 1; bv = 1; bt = 2'b11; bb = 1; ns = 2'b01; end
    end
    return {1'b1, ns, co, fl, rt, pu, rd, wr, bv, bt, bb, bv & g};
  endfunction

  function automatic string tag(input logic v, st, input logic [1:0] s,
                                input logic h, wt, ci);
    logic eh, em;
    eh = h && (s == 2'b01 || s == 2'b10);
    em = h && (s == 2'b10);
    if (!v) return "R1";
    if (ci) return !eh ? (st ? "R9" : "R4") : (em ? "R6" : "R5");
    if (!st) return eh ? "R3" : "R2";
    if (!wt) return eh ? "R8" : "R7";
    return !eh ? "R9" : (em ? "R11" : "R10");
  endfunction

  function automatic logic [14:0] outs();
    return {rsp_valid, nxt_state, do_castout, do_fill, do_retry, do_push, cache_rd,
            cache_wr, bus_req, bus_type, bus_burst, bus_global};
  endfunction

  task automatic check(input string r, input logic [14:0] exp);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", r, outs(), exp);
    end
  endtask

  task automatic access(input logic v, st, input logic [1:0] s,
                        input logic h, vd, wt, ci, g, input string extra = "");
    string r;
    req_valid = v; req_store = st; line_state = s; tag_hit = h;
    victim_dirty = vd; attr_wt = wt; attr_ci = ci; attr_gbl = g;
    r = {tag(v, st, s, h, wt, ci), extra};
    @(negedge clk);
    check(r, model(v, st, s, h, vd, wt, ci, g));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 15'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle", 15'd0);
    // R2 load miss with and without dirty victim, write-through ignored for loads
    access(1, 0, 2'b00, 0, 1, 0, 0, 1);
    access(1, 0, 2'b00, 0, 0, 1, 0, 0);
    // R3 load hits
    access(1, 0, 2'b01, 1, 1, 0, 0, 1);
    access(1, 0, 2'b10, 1, 0, 1, 0, 0);
    // R4 / R5 / R6 caching-inhibited loads
    access(1, 0, 2'b00, 0, 1, 0, 1, 1);
    access(1, 0, 2'b01, 1, 0, 0, 1, 0);
    access(1, 0, 2'b10, 1, 1, 0, 1, 1);
    // R7 / R8 copy-back stores
    access(1, 1, 2'b00, 0, 1, 0, 0, 1);
    access(1, 1, 2'b01, 1, 0, 0, 0, 0);
    access(1, 1, 2'b10, 1, 1, 0, 0, 1);
    // R9 R10 R11 write-through stores, R12 CI store hit E
    access(1, 1, 2'b00, 0, 1, 1, 0, 1);
    access(1, 1, 2'b01, 1, 1, 1, 0, 1);
    access(1, 1, 2'b10, 1, 0, 1, 0, 0);
    access(1, 1, 2'b01, 1, 0, 0, 1, 1, " R12");
    access(1, 1, 2'b00, 0, 1, 1, 1, 0);
    // R12 tag match on Invalid / reserved counts as miss
    access(1, 0, 2'b00, 1, 1, 0, 0, 0, " R12");
    access(1, 1, 2'b11, 1, 0, 0, 0, 0, " R12");
    access(1, 1, 2'b11, 1, 1, 1, 0, 1, " R12");
    // R11 retry then re-present with produced state
    access(1, 1, 2'b10, 1, 0, 1, 0, 1);
    access(1, 1, nxt_state, 1, 0, 1, 0, 1, " R11 replay");
    // R6 CI store hit Modified, then replay sees Invalid -> R9
    access(1, 1, 2'b10, 1, 0, 0, 1, 0);
    access(1, 1, nxt_state, 1, 0, 0, 1, 0, " R6 replay");
    // R13 coherence bit with no bus op changes nothing
    access(1, 0, 2'b01, 1, 0, 0, 0, 1, " R13");
    access(0, 1, 2'b10, 1, 1, 1, 1, 1);
    // random traffic
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 2000; i++) begin
      logic [7:0] rv;
      logic [1:0] sv;
      rv = 8'($urandom());
      sv = 2'($urandom());
      access(rv[7] | rv[6] | rv[5], rv[0], sv, rv[1], rv[2], rv[3], rv[4] & rv[5], rv[6]);
    end
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset again", 15'd0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule